// File: doc/BRIEF.md
# Board Control and Test Register Bank

This block is a small register bank on a simple synchronous local-bus slave port. It holds one 8-bit board control register, a fixed read-only revision byte, and one 32-bit test word that two addresses share. The control register drives a set of user LEDs and the write-protect line of the board's configuration EEPROMs. It also turns one exact 3-bit code, written into its top three bits, into a one-cycle hard-reset request for an external reset sequencer.

The test word gives software a way to check the bus data path. The first test address reads and writes the word as stored. The second test address reads back the bitwise complement of that word, and a write there stores its data without inversion. Every read returns its data one clock after the read strobe. Unmapped addresses read as zero and ignore writes.

Top module: `boardctl_regbank`

## Requirements
- R1: After reset, the LED outputs are all 0, `eeprom_wp` is 1, `hard_reset_req` is 0, the control register reads 0x10 and the test word reads 0x00000000.
- R2: A write to the control address (0x00) with data bits 7:5 equal to 3'b101 sets `hard_reset_req` to 1 for exactly one cycle. The pulse appears in the cycle that follows the write edge.
- R3: A control write with any other value in bits 7:5 leaves `hard_reset_req` at 0.
- R4: Control bits 7:5 always read back as 0.
- R5: `eeprom_wp` follows control bit 4 after each control write. The value 1 protects the devices and 0 enables writes.
- R6: `led_on[i]` follows control bit i (i below LED_COUNT, default 3) after each control write. The value 1 lights the LED.
- R7: The revision address (0x01) reads REV_ID (default 0x01) in bits 7:0 with zeros above, and writes there change nothing.
- R8: The test-1 address (0x04) stores a full 32-bit write and reads it back unchanged.
- R9: A read of the test-2 address (0x05) returns the bitwise complement of the stored test word.
- R10: A write to the test-2 address stores its data uncomplemented, so that test-1 then reads that data.
- R11: Read data is valid in the cycle after the read strobe. An unmapped address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| led_on | output | LED_COUNT (3) | User LED drives, 1 lights |
| eeprom_wp | output | 1 | EEPROM write protect, 1 protects |
| hard_reset_req | output | 1 | One-cycle hard-reset request |

## Verification
The bench writes all eight values of the reset field. Only 3'b101 may pulse the reset output, and that pulse must drop after one cycle. A design that decoded a single bit would fire on 3'b100 or 3'b111, and a level-held request would show up on the second sampled cycle. The bench reads the test word through both addresses after writes through each one. A design that complemented on the write side, or not at all, returns the wrong pattern at one of the two addresses. Writes to the revision byte and to an unmapped address are followed by readback, which catches a decoder that aliases addresses or lets the constant be overwritten.

// File: rtl/boardctl_pkg.sv
package boardctl_pkg;

   // one select line per mapped register
   typedef struct packed {
      logic ctrl;
      logic rev;
      logic tst1;
      logic tst2;
   } boardctl_sel_t;

   // control-register field positions
   localparam int unsigned CTL_W       = 8;
   localparam int unsigned WP_BIT      = 4;
   localparam int unsigned RST_LSB     = 5;
   localparam int unsigned RST_MSB     = 7;
   localparam logic [2:0]  RST_CODE    = 3'b101;
   localparam int unsigned LED_MAX     = 4;

endpackage

// File: rtl/boardctl_decode.sv
module boardctl_decode
   import boardctl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CTRL_OFS  = 0,
   parameter int unsigned REV_OFS   = 1,
   parameter int unsigned TEST1_OFS = 4,
   parameter int unsigned TEST2_OFS = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output boardctl_sel_t     sel
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(REV_OFS);
   localparam logic [ADDR_W-1:0] A_T1   = ADDR_W'(TEST1_OFS);
   localparam logic [ADDR_W-1:0] A_T2   = ADDR_W'(TEST2_OFS);

   // offsets must be distinct and fit the address width
   if ((CTRL_OFS == REV_OFS) || (CTRL_OFS == TEST1_OFS) || (CTRL_OFS == TEST2_OFS) ||
       (REV_OFS == TEST1_OFS) || (REV_OFS == TEST2_OFS) || (TEST1_OFS == TEST2_OFS)) begin : g_bad_ofs
      $error("boardctl_decode: register offsets overlap");
   end
   if ((CTRL_OFS >= (1 << ADDR_W)) || (REV_OFS >= (1 << ADDR_W)) ||
       (TEST1_OFS >= (1 << ADDR_W)) || (TEST2_OFS >= (1 << ADDR_W))) begin : g_bad_aw
      $error("boardctl_decode: offset exceeds address width");
   end

   always_comb begin
      sel      = '0;
      sel.ctrl = (addr == A_CTRL);
      sel.rev  = (addr == A_REV);
      sel.tst1 = (addr == A_T1);
      sel.tst2 = (addr == A_T2);
   end

endmodule

// File: rtl/boardctl_sysctrl.sv
module boardctl_sysctrl
   import boardctl_pkg::*;
#(
   parameter int unsigned LED_COUNT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [CTL_W-1:0]     wdata,
   output logic [CTL_W-1:0]     rb,
   output logic [LED_COUNT-1:0] led_on,
   output logic                 eeprom_wp,
   output logic                 hard_reset_req
);

   if (LED_COUNT < 1 || LED_COUNT > LED_MAX) begin : g_bad_led
      $error("boardctl_sysctrl: LED_COUNT must be 1..4");
   end

   logic [LED_COUNT-1:0] led_q;
   logic                 wp_q;
   logic                 pulse_q;
   logic                 code_hit;

   assign code_hit = (wdata[RST_MSB:RST_LSB] == RST_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q   <= '0;
         wp_q    <= 1'b1;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= we && code_hit;
         if (we) begin
            led_q <= wdata[LED_COUNT-1:0];
            wp_q  <= wdata[WP_BIT];
         end
      end
   end

   // one output per LED
   for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
      assign led_on[i] = led_q[i];
   end

   assign eeprom_wp      = wp_q;
   assign hard_reset_req = pulse_q;

   // reset-code field never stored, reads zero
   always_comb begin
      rb                 = '0;
      rb[WP_BIT]         = wp_q;
      rb[LED_COUNT-1:0]  = led_q;
   end

   assert_reset_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[RST_MSB:RST_LSB] == 3'b101) |=> hard_reset_req);

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_reset_req && !(we && wdata[RST_MSB:RST_LSB] == 3'b101)) |=> !hard_reset_req);

   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hard_reset_req |-> ($past(we) && $past(wdata[RST_MSB:RST_LSB]) == 3'b101));

   assert_wp_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (eeprom_wp == $past(wdata[WP_BIT])));

   assert_wp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(eeprom_wp));

endmodule

// File: rtl/boardctl_testword.sv
module boardctl_testword #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] word_q,
   output logic [DATA_W-1:0] word_inv
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (we) word_q <= wdata;
   end

   assign word_inv = ~word_q;

   assert_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (word_q == $past(wdata)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(word_q));

endmodule

// File: rtl/boardctl_regbank.sv
module boardctl_regbank
   import boardctl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LED_COUNT = 3,
   parameter logic [7:0]  REV_ID    = 8'h01,
   parameter bit          RD_REG    = 1'b1,
   parameter int unsigned CTRL_OFS  = 0,
   parameter int unsigned REV_OFS   = 1,
   parameter int unsigned TEST1_OFS = 4,
   parameter int unsigned TEST2_OFS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [LED_COUNT-1:0] led_on,
   output logic                 eeprom_wp,
   output logic                 hard_reset_req
);

   localparam int unsigned PAD_W = DATA_W - CTL_W;

   if (DATA_W < CTL_W) begin : g_bad_dw
      $error("boardctl_regbank: DATA_W must be at least 8");
   end

   boardctl_sel_t     sel;
   logic [CTL_W-1:0]  ctrl_rb;
   logic [DATA_W-1:0] tw_q;
   logic [DATA_W-1:0] tw_inv;
   logic [DATA_W-1:0] rd_mux;

   boardctl_decode #(
      .ADDR_W    (ADDR_W),
      .CTRL_OFS  (CTRL_OFS),
      .REV_OFS   (REV_OFS),
      .TEST1_OFS (TEST1_OFS),
      .TEST2_OFS (TEST2_OFS)
   ) i_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   boardctl_sysctrl #(
      .LED_COUNT (LED_COUNT)
   ) i_sysctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .we             (bus_wr && sel.ctrl),
      .wdata          (bus_wdata[CTL_W-1:0]),
      .rb             (ctrl_rb),
      .led_on         (led_on),
      .eeprom_wp      (eeprom_wp),
      .hard_reset_req (hard_reset_req)
   );

   boardctl_testword #(
      .DATA_W (DATA_W)
   ) i_testword (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_wr && (sel.tst1 || sel.tst2)),
      .wdata    (bus_wdata),
      .word_q   (tw_q),
      .word_inv (tw_inv)
   );

   always_comb begin
      rd_mux = '0;
      if (sel.ctrl)      rd_mux = {{PAD_W{1'b0}}, ctrl_rb};
      else if (sel.rev)  rd_mux = {{PAD_W{1'b0}}, REV_ID};
      else if (sel.tst1) rd_mux = tw_q;
      else if (sel.tst2) rd_mux = tw_inv;
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (bus_rd) rdata_q <= rd_mux;
      end
      assign bus_rdata = rdata_q;

      assert_inverse_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(TEST2_OFS)) |=> (bus_rdata == ~$past(tw_q)));

      assert_rev_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(REV_OFS)) |=> (bus_rdata == {{PAD_W{1'b0}}, REV_ID}));

      assert_rst_field_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(CTRL_OFS)) |=> (bus_rdata[7:5] == 3'b000));
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end

   assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel.ctrl, sel.rev, sel.tst1, sel.tst2}));

endmodule

// File: tb/test_boardctl_regbank.sv
`timescale 1ns/1ps
module test_boardctl_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  led_on;
   logic        eeprom_wp;
   logic        hard_reset_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   boardctl_regbank i_boardctl_regbank (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_wr         (bus_wr),
      .bus_rd         (bus_rd),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .led_on         (led_on),
      .eeprom_wp      (eeprom_wp),
      .hard_reset_req (hard_reset_req)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: one-cycle write
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: one-cycle read, expectation pushed to the scoreboard
   task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string req);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(req);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // control write with pulse check: high on the first sample, low on the next
   task automatic ctrl_write(input logic [7:0] d, input bit want_pulse, input string req);
      bus_write(8'h00, {24'h0, d});
      check(hard_reset_req == want_pulse, req, {31'h0, hard_reset_req}, {31'h0, want_pulse});
      @(negedge clk);
      check(hard_reset_req == 1'b0, req, {31'h0, hard_reset_req}, 32'h0);
   endtask

   // monitor: compare read data the cycle after each strobe (R11 latency)
   initial begin
      logic [31:0] e;
      string t;
      forever begin
         @(posedge clk);
         if (bus_rd) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected read", bus_rdata, 32'h0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(bus_rdata === e, t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(led_on == 3'b000, "R1 leds", {29'h0, led_on}, 32'h0);
      check(eeprom_wp == 1'b1, "R1 wp", {31'h0, eeprom_wp}, 32'h1);
      check(hard_reset_req == 1'b0, "R1 rst", {31'h0, hard_reset_req}, 32'h0);
      bus_read(8'h00, 32'h0000_0010, "R1 ctrl");
      bus_read(8'h04, 32'h0000_0000, "R1 test word");
      bus_read(8'h05, 32'hFFFF_FFFF, "R9 reset complement");

      // R7 revision constant, write ignored
      bus_read(8'h01, 32'h0000_0001, "R7 rev");
      bus_write(8'h01, 32'hFFFF_FFAB);
      bus_read(8'h01, 32'h0000_0001, "R7 rev after write");

      // R2 exact code fires once; R5, R6 fields follow
      ctrl_write(8'hA5, 1'b1, "R2 pulse");
      check(led_on == 3'b101, "R6 leds", {29'h0, led_on}, 32'h5);
      check(eeprom_wp == 1'b0, "R5 wp cleared", {31'h0, eeprom_wp}, 32'h0);
      bus_read(8'h00, 32'h0000_0005, "R4 code reads zero");

      // R3 every other code stays quiet
      for (int c = 0; c < 8; c++) begin
         if (c != 5) begin
            ctrl_write({c[2:0], 5'b10011}, 1'b0, "R3 no pulse");
            check(led_on == 3'b011, "R6 leds", {29'h0, led_on}, 32'h3);
            check(eeprom_wp == 1'b1, "R5 wp set", {31'h0, eeprom_wp}, 32'h1);
         end
      end
      bus_read(8'h00, 32'h0000_0013, "R4 readback");

      // R2 back-to-back reset writes: a pulse for each one
      ctrl_write(8'hA0, 1'b1, "R2 pulse again");
      check(led_on == 3'b000, "R6 leds off", {29'h0, led_on}, 32'h0);

      // R8, R9 test word via address 0x04
      bus_write(8'h04, 32'h1234_5678);
      bus_read(8'h04, 32'h1234_5678, "R8 test1");
      bus_read(8'h05, 32'hEDCB_A987, "R9 test2 complement");

      // R10 write via 0x05 stores uncomplemented
      bus_write(8'h05, 32'hCAFE_F00D);
      bus_read(8'h04, 32'hCAFE_F00D, "R10 test1 after test2 write");
      bus_read(8'h05, 32'h3501_0FF2, "R10 test2 complement");

      // R11 unmapped address
      bus_write(8'h02, 32'hFFFF_FFFF);
      bus_read(8'h02, 32'h0000_0000, "R11 unmapped read");
      bus_read(8'h00, 32'h0000_0000, "R11 ctrl untouched");
      bus_read(8'h04, 32'hCAFE_F00D, "R11 test word untouched");
      check(hard_reset_req == 1'b0, "R11 no pulse", {31'h0, hard_reset_req}, 32'h0);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule